// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the register front end of an I/O interrupt router. A host reaches it through a small 32-bit memory-mapped bus. It decodes three offsets: an index register, a data window and an end-of-interrupt port. The index register picks which internal register the data window reaches. Behind the window sit an identification register, a read-only version word, an arbitration alias of the identification register, and a table of 64-bit redirection entries. Each table entry is reached as two 32-bit halves.

Every accepted table write produces a one-cycle request to the downstream pin servicer, carrying the entry index. Writes to the end-of-interrupt port are passed on as a vector strobe. The servicer reports delivery-status and remote-request state back into the table through a status port. Bus writes cannot change those bits.

Top module: `ioapic_reg_window`

## Requirements
- R1: Only address bits 7:0 are decoded. Bits 11:8 have no effect. Offsets are: index register 0x00, data window 0x10, end-of-interrupt port 0x40.
- R2: The index register (8 bits) is written and read back at offset 0x00 with any access size.
- R3: The data window acts only on 4-byte accesses. The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 reserved. A window write of any other size changes nothing and requests no servicing. A window read of any other size returns 0.
- R4: Index 0x00 (identification) and index 0x02 (arbitration) both read the 4-bit identifier in data bits 27:24, with all other bits zero. A window write at index 0x00 loads only data bits 27:24 into the identifier. Window writes at index 0x01 and 0x02 are ignored.
- R5: Index 0x01 reads VERSION in bits 7:0 and NUM_PINS-1 in bits 23:16.
- R6: An index of 0x10 or above selects entry (index-0x10)/2. Odd indices reach entry bits 63:32 and even indices reach bits 31:0. Entries at or beyond NUM_PINS read 0, and writes to them are ignored. Indices 0x03 to 0x0F read 0.
- R7: A table write merges the new half, keeps only the writable bits, and restores the previous delivery-status bit (12) and remote-request bit (14). The writable bits are 7:0, 10:8, 11, 13, 15, 16 and 63:56. A status-port update sets bits 12 and 14 of the chosen entry. It is dropped if a bus table write hits the same entry in the same cycle.
- R8: After a table write, if trigger bit 15 of the entry is 0 (edge), remote-request bit 14 is cleared.
- R9: One cycle after each accepted table write, svc_req pulses for one cycle with svc_pin equal to the entry index. It never pulses otherwise.
- R10: A 4-byte write at offset 0x40 gives eoi_valid one cycle later, with eoi_vector equal to data bits 7:0. This happens only when VERSION is 0x20. Other sizes are ignored.
- R11: After reset the index register and the identifier are 0. Every entry holds only mask bit 16 set (0x0000_0000_0001_0000).
- R12: A read returns bus_rdata with bus_rvalid one cycle after the request. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB region |
| bus_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| st_en | input | 1 | Status update strobe from servicer |
| st_pin | input | PIN_W | Entry to update |
| st_dlvs | input | 1 | New delivery-status bit |
| st_rirr | input | 1 | New remote-request bit |
| svc_req | output | 1 | Servicing request after a table write |
| svc_pin | output | PIN_W | Entry that was written |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | End-of-interrupt vector |

## Verification
Table writes use several kinds of data:
- All-ones data shows that the writable mask strips reserved bits in each half.
- Level-mode and edge-mode values written over an entry whose status bits were set from the status port show that read-only bits are restored and that the edge fix-up clears only the remote-request bit.
- Writes that try to clear the read-only bits show that they are protected.

Window accesses of the wrong size, out-of-range and reserved indices, and aliased upper address bits each check that nothing changes and that no servicing request or vector strobe appears.

// File: rtl/ioapic_win_pkg.sv
package ioapic_win_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int ENTRY_W = 64;
    localparam int IDX_W   = 7;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [7:0] SEL_TBL = 8'h10;

    localparam int ID_LSB   = 24;
    localparam int ID_W     = 4;
    localparam int BIT_DLVS = 12;
    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;

    localparam logic [ENTRY_W-1:0] RW_MASK     = 64'hFF00_0000_0001_AFFF;
    localparam logic [ENTRY_W-1:0] RO_MASK     = 64'h0000_0000_0000_5000;
    localparam logic [ENTRY_W-1:0] RESET_ENTRY = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {SZ_1 = 2'd0, SZ_2 = 2'd1, SZ_4 = 2'd2, SZ_RSV = 2'd3} bus_size_e;

    typedef enum logic [2:0] {TGT_NONE, TGT_ID, TGT_VER, TGT_ARB, TGT_TBL} win_tgt_e;

    typedef struct packed {
        logic             hit_sel;
        logic             hit_win;
        logic             hit_eoi;
        win_tgt_e         tgt;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [ENTRY_W-1:0] merge_entry(
        input logic [ENTRY_W-1:0] old_e,
        input logic [DATA_W-1:0]  half,
        input logic               hi
    );
        logic [ENTRY_W-1:0] n;
        n = hi ? {half, old_e[31:0]} : {old_e[63:32], half};
        n = (n & RW_MASK) | (old_e & RO_MASK);
        if (!n[BIT_TRIG]) begin
            n[BIT_RIRR] = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/ioapic_win_decode.sv
module ioapic_win_decode
    import ioapic_win_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [7:0] off,
    input  logic [7:0] sel,
    output dec_t       dec
);
    logic [7:0] tbl_off;

    always_comb begin
        tbl_off     = sel - SEL_TBL;
        dec         = '0;
        dec.tgt     = TGT_NONE;
        dec.hit_sel = (off == OFF_SEL);
        dec.hit_win = (off == OFF_WIN);
        dec.hit_eoi = (off == OFF_EOI);
        dec.hi      = sel[0];
        dec.idx     = tbl_off[7:1];
        case (sel)
            SEL_ID:  dec.tgt = TGT_ID;
            SEL_VER: dec.tgt = TGT_VER;
            SEL_ARB: dec.tgt = TGT_ARB;
            default: begin
                if (sel >= SEL_TBL && int'(tbl_off[7:1]) < NUM_PINS) begin
                    dec.tgt = TGT_TBL;
                end
            end
        endcase
    end
endmodule

// File: rtl/ioapic_redir_table.sv
module ioapic_redir_table
    import ioapic_win_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PIN_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_half,
    input  logic              st_en,
    input  logic [PIN_W-1:0]  st_pin,
    input  logic              st_dlvs,
    input  logic              st_rirr,
    input  logic [PIN_W-1:0]  rd_idx,
    input  logic              rd_hi,
    output logic [DATA_W-1:0] rd_half
);
    logic [ENTRY_W-1:0] tbl [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[p] <= RESET_ENTRY;
            end else if (wr_en && wr_idx == PIN_W'(p)) begin
                tbl[p] <= merge_entry(tbl[p], wr_half, wr_hi);
            end else if (st_en && st_pin == PIN_W'(p)) begin
                tbl[p][BIT_DLVS] <= st_dlvs;
                tbl[p][BIT_RIRR] <= st_rirr;
            end
        end
    end

    always_comb begin
        rd_half = '0;
        if (int'(rd_idx) < NUM_PINS) begin
            rd_half = rd_hi ? tbl[rd_idx][63:32] : tbl[rd_idx][31:0];
        end
    end

    // R8
    edge_rirr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl[$past(wr_idx)][BIT_TRIG] || !tbl[$past(wr_idx)][BIT_RIRR]));

    // R7
    ro_dlvs_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl[$past(wr_idx)][BIT_DLVS] == $past(tbl[wr_idx][BIT_DLVS])));

    // R7
    st_update_chk: assert property (@(posedge clk) disable iff (rst)
        (st_en && !(wr_en && wr_idx == st_pin)) |=>
            (tbl[$past(st_pin)][BIT_DLVS] == $past(st_dlvs)));
endmodule

// File: rtl/ioapic_reg_window.sv
module ioapic_reg_window
    import ioapic_win_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h20,
    localparam int         PIN_W    = $clog2(NUM_PINS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    input  logic               st_en,
    input  logic [PIN_W-1:0]   st_pin,
    input  logic               st_dlvs,
    input  logic               st_rirr,
    output logic               svc_req,
    output logic [PIN_W-1:0]   svc_pin,
    output logic               eoi_valid,
    output logic [7:0]         eoi_vector
);
    localparam logic [DATA_W-1:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
    localparam logic              EOI_ON   = (VERSION == 8'h20);

    logic [7:0]        sel_q;
    logic [ID_W-1:0]   id_q;
    dec_t              dec;
    logic              win4;
    logic              tbl_wr;
    logic              eoi_hit;
    logic [DATA_W-1:0] tbl_half;
    logic [DATA_W-1:0] rd_mux;
    logic [PIN_W-1:0]  tbl_idx;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[ADDR_W-1:8], dec.idx};

    ioapic_win_decode #(.NUM_PINS(NUM_PINS)) dec_i (
        .off (bus_addr[7:0]),
        .sel (sel_q),
        .dec (dec)
    );

    assign win4    = (bus_size == SZ_4);
    assign tbl_idx = dec.idx[PIN_W-1:0];
    assign tbl_wr  = bus_req && bus_we && dec.hit_win && win4 && dec.tgt == TGT_TBL;
    assign eoi_hit = bus_req && bus_we && dec.hit_eoi && win4 && EOI_ON;

    ioapic_redir_table #(.NUM_PINS(NUM_PINS)) tbl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr),
        .wr_idx  (tbl_idx),
        .wr_hi   (dec.hi),
        .wr_half (bus_wdata),
        .st_en   (st_en),
        .st_pin  (st_pin),
        .st_dlvs (st_dlvs),
        .st_rirr (st_rirr),
        .rd_idx  (tbl_idx),
        .rd_hi   (dec.hi),
        .rd_half (tbl_half)
    );

    always_comb begin
        rd_mux = '0;
        if (dec.hit_sel) begin
            rd_mux = {24'h0, sel_q};
        end else if (dec.hit_win && win4) begin
            case (dec.tgt)
                TGT_ID, TGT_ARB: rd_mux = {4'h0, id_q, 24'h0};
                TGT_VER:         rd_mux = VER_WORD;
                TGT_TBL:         rd_mux = tbl_half;
                default:         rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            id_q       <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            svc_req    <= 1'b0;
            svc_pin    <= '0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            if (bus_req && !bus_we) begin
                bus_rdata <= rd_mux;
            end
            if (bus_req && bus_we && dec.hit_sel) begin
                sel_q <= bus_wdata[7:0];
            end
            if (bus_req && bus_we && dec.hit_win && win4 && dec.tgt == TGT_ID) begin
                id_q <= bus_wdata[ID_LSB +: ID_W];
            end
            svc_req <= tbl_wr;
            if (tbl_wr) begin
                svc_pin <= tbl_idx;
            end
            eoi_valid <= eoi_hit;
            if (eoi_hit) begin
                eoi_vector <= bus_wdata[7:0];
            end
        end
    end

    // R9
    svc_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_wr |=> (svc_req && svc_pin == $past(tbl_idx)));

    // R9
    svc_only_wr_chk: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> $past(tbl_wr));

    // R10
    eoi_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_hit |=> (eoi_valid && eoi_vector == $past(bus_wdata[7:0])));

    // R3
    win_size_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && dec.hit_win && !win4) |=> (!svc_req && $stable(id_q)));

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);
endmodule

// File: tb/ioapic_reg_window_tb_top.sv
module ioapic_reg_window_tb_top;
    localparam int NP    = 24;
    localparam int PW    = $clog2(NP);
    localparam logic [63:0] TB_RW = 64'hFF00_0000_0001_AFFF;
    localparam logic [63:0] TB_RO = 64'h0000_0000_0000_5000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          st_en = 1'b0, st_dlvs = 1'b0, st_rirr = 1'b0;
    logic [PW-1:0] st_pin = '0;
    logic          svc_req, eoi_valid;
    logic [PW-1:0] svc_pin;
    logic [7:0]    eoi_vector;

    ioapic_reg_window #(.NUM_PINS(NP), .VERSION(8'h20)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .st_en(st_en), .st_pin(st_pin), .st_dlvs(st_dlvs), .st_rirr(st_rirr),
        .svc_req(svc_req), .svc_pin(svc_pin),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;

    exp_t rd_q[$];
    exp_t svc_q[$];
    exp_t eoi_q[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic [63:0] m_tbl [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rvalid) begin
                if (rd_q.size() == 0) check("R12 unexpected read", bus_rdata, 32'hxxxx_xxxx);
                else begin mon_e = rd_q.pop_front(); check(mon_e.tag, bus_rdata, mon_e.val); end
            end
            if (svc_req) begin
                if (svc_q.size() == 0) check("R9 unexpected svc_req", 32'(svc_pin), 32'hFFFF_FFFF);
                else begin mon_e = svc_q.pop_front(); check(mon_e.tag, 32'(svc_pin), mon_e.val); end
            end
            if (eoi_valid) begin
                if (eoi_q.size() == 0) check("R10 unexpected eoi_valid", 32'(eoi_vector), 32'hFFFF_FFFF);
                else begin mon_e = eoi_q.pop_front(); check(mon_e.tag, 32'(eoi_vector), mon_e.val); end
            end
        end
    end

    task automatic drive(logic we, logic [11:0] a, logic [1:0] sz, logic [31:0] d);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [1:0] sz, logic [31:0] d, string tag);
        logic [63:0] n;
        int          idx;
        @(negedge clk);
        if (a[7:0] == 8'h00) m_sel = d[7:0];
        else if (a[7:0] == 8'h10 && sz == 2'd2) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (m_sel >= 8'h10) begin
                idx = (int'(m_sel) - 16) / 2;
                if (idx < NP) begin
                    n = m_sel[0] ? {d, m_tbl[idx][31:0]} : {m_tbl[idx][63:32], d};
                    n = (n & TB_RW) | (m_tbl[idx] & TB_RO);
                    if (!n[15]) n[14] = 1'b0;
                    m_tbl[idx] = n;
                    svc_q.push_back('{tag, 32'(idx)});
                end
            end
        end else if (a[7:0] == 8'h40 && sz == 2'd2) begin
            eoi_q.push_back('{tag, {24'h0, d[7:0]}});
        end
        drive(1'b1, a, sz, d);
    endtask

    task automatic rd(logic [11:0] a, logic [1:0] sz, string tag);
        logic [31:0] e;
        int          idx;
        @(negedge clk);
        e = '0;
        if (a[7:0] == 8'h00) e = {24'h0, m_sel};
        else if (a[7:0] == 8'h10 && sz == 2'd2) begin
            if (m_sel == 8'h00 || m_sel == 8'h02) e = {4'h0, m_id, 24'h0};
            else if (m_sel == 8'h01) e = 32'h0017_0020;
            else if (m_sel >= 8'h10) begin
                idx = (int'(m_sel) - 16) / 2;
                if (idx < NP) e = m_sel[0] ? m_tbl[idx][63:32] : m_tbl[idx][31:0];
            end
        end
        rd_q.push_back('{tag, e});
        drive(1'b0, a, sz, 32'h0);
    endtask

    task automatic status(int pin, logic dl, logic ri);
        @(negedge clk);
        st_en = 1'b1; st_pin = PW'(pin); st_dlvs = dl; st_rirr = ri;
        m_tbl[pin][12] = dl; m_tbl[pin][14] = ri;
        @(negedge clk);
        st_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NP; i++) m_tbl[i] = 64'h1_0000;
        m_sel = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state, R2 select read-back
        rd(12'h000, 2'd2, "R11 select reset");
        for (int i = 0; i < NP; i++) begin
            wr(12'h000, 2'd2, 32'(8'h10 + 2 * i), "R2 sel");
            rd(12'h010, 2'd2, "R11 entry low reset");
            wr(12'h000, 2'd0, 32'(8'h11 + 2 * i), "R2 sel byte");
            rd(12'h010, 2'd2, "R11 entry high reset");
        end
        rd(12'h000, 2'd0, "R2 select byte read");

        // R4 identifier and arbitration
        wr(12'h000, 2'd2, 32'h0, "R2");
        rd(12'h010, 2'd2, "R11 id reset");
        wr(12'h010, 2'd2, 32'hFFFF_FFFF, "R4");
        rd(12'h010, 2'd2, "R4 id read");
        wr(12'h000, 2'd2, 32'h2, "R2");
        rd(12'h010, 2'd2, "R4 arb alias read");
        wr(12'h010, 2'd2, 32'h0, "R4 arb write ignored");
        rd(12'h010, 2'd2, "R4 arb after write");
        wr(12'h000, 2'd2, 32'h1, "R2");
        wr(12'h010, 2'd2, 32'h0, "R4 version write ignored");
        rd(12'h010, 2'd2, "R5 version word");

        // R3 size filtering
        wr(12'h000, 2'd2, 32'h0, "R2");
        wr(12'h010, 2'd1, 32'h0, "R3 half write");
        wr(12'h010, 2'd3, 32'h0, "R3 reserved size");
        rd(12'h010, 2'd2, "R3 id unchanged");
        rd(12'h010, 2'd0, "R3 byte read zero");

        // R6, R7, R9 table halves and mask
        wr(12'h000, 2'd2, 32'h12, "R6");
        wr(12'h010, 2'd2, 32'hFFFF_FFFF, "R9 svc entry1 lo");
        rd(12'h010, 2'd2, "R7 lo writable mask");
        wr(12'h000, 2'd2, 32'h13, "R6");
        wr(12'h010, 2'd2, 32'hFFFF_FFFF, "R9 svc entry1 hi");
        rd(12'h010, 2'd2, "R6 hi half");
        wr(12'h000, 2'd2, 32'h12, "R6");
        rd(12'h010, 2'd2, "R6 lo kept after hi write");

        // R7, R8 read-only bits and edge fix-up
        status(3, 1'b1, 1'b1);
        wr(12'h000, 2'd2, 32'h16, "R6");
        rd(12'h010, 2'd2, "R7 status port update");
        wr(12'h010, 2'd2, 32'h0000_0031, "R9 svc entry3 edge");
        rd(12'h010, 2'd2, "R8 edge clears remote bit");
        status(3, 1'b1, 1'b1);
        wr(12'h010, 2'd2, 32'h0000_8031, "R9 svc entry3 level");
        rd(12'h010, 2'd2, "R7 level keeps ro bits");
        wr(12'h010, 2'd2, 32'h0000_8000, "R9 svc entry3 clr try");
        rd(12'h010, 2'd2, "R7 ro bits protected");

        // R6 out of range, reserved selects
        wr(12'h000, 2'd2, 32'h40, "R6");
        wr(12'h010, 2'd2, 32'hFFFF_FFFF, "R6 oor write ignored");
        rd(12'h010, 2'd2, "R6 oor read zero");
        wr(12'h000, 2'd2, 32'h3F, "R6");
        rd(12'h010, 2'd2, "R6 last entry hi");
        wr(12'h000, 2'd2, 32'h05, "R6");
        rd(12'h010, 2'd2, "R6 reserved select zero");

        // R10 end of interrupt
        wr(12'h040, 2'd2, 32'h1234_5678, "R10 eoi vector");
        wr(12'h040, 2'd0, 32'h0000_0099, "R10 byte eoi ignored");
        wr(12'h040, 2'd2, 32'h0000_00A5, "R10 second eoi");

        // R1 aliasing, R12 unmapped
        wr(12'hF00, 2'd2, 32'h2E, "R1 alias select");
        rd(12'h300, 2'd2, "R1 alias select read");
        wr(12'h510, 2'd2, 32'h0000_0042, "R1 R9 alias window write");
        rd(12'hA10, 2'd2, "R1 alias window read");
        rd(12'h020, 2'd2, "R12 unmapped read");

        repeat (4) @(negedge clk);
        if (rd_q.size() != 0)  check("R12 missing read", 32'(rd_q.size()), 0);
        if (svc_q.size() != 0) check("R9 missing svc", 32'(svc_q.size()), 0);
        if (eoi_q.size() != 0) check("R10 missing eoi", 32'(eoi_q.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule